// File: doc/BRIEF.md
# Page Buffer Load Controller

This block gathers the bytes of one flash page into a 128-byte staging buffer after the command decoder accepts either a program command or a buffer-write command. Each host write strobe is given as two one-cycle pulses. The falling-edge pulse captures a 20-bit address: the low 7 bits are the byte offset within the page and the upper 13 bits are the page number. The rising-edge pulse captures the data byte. Bytes may arrive in any order.

In program mode the buffer is preset to the erased value (FFh) when the mode starts. The load window closes in one of two ways: the inter-strobe gap, counted in microsecond ticks, reaches a limit, or the same offset is written twice in a row. When the window closes, the block pulses a program-start strobe. It then holds the page number stable until the program engine acknowledges. The engine fetches the buffer contents through the same byte-offset read port that the host uses.

In buffer-write mode the buffer acts as scratch storage. That mode ends by itself after a shorter gap and does not start programming. A clear command fills the whole buffer with FFh.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset the block is idle. `load_active_o`, `prog_busy_o`, `prog_start_o` and `page_err_o` are 0, and every buffer byte reads FFh.
- R2: Accepting a program command (`arm_prog_i` while idle) presets all 128 bytes to FFh. Any offset not written during the window then reads FFh.
- R3: Each accepted strobe stores its data byte at offset `addr_i[6:0]`, in any order. `rd_data_o` always shows the byte at `rd_off_i`.
- R4: In program mode, once a byte has been stored, a run of PROG_GAP ticks after a rising-edge pulse with no new falling-edge pulse closes the window on the PROG_GAP-th tick edge. `prog_start_o` is then high for exactly one cycle, `prog_busy_o` rises, and `prog_page_o` equals `addr_i[19:7]` of the first strobe.
- R5: In program mode, a strobe whose offset equals that of the immediately preceding stored strobe closes the window on its rising-edge pulse. Its data is discarded, and the first byte at that offset is kept.
- R6: In program mode, a strobe whose page number differs from the captured one sets `page_err_o`. The byte is still stored by offset. The flag clears on the next accepted program command.
- R7: While `prog_busy_o` is high, `prog_page_o` is stable, and strobes, clear and arm inputs have no effect. A `prog_ack_i` pulse returns the block to idle.
- R8: Buffer-write mode (`arm_bufwr_i` while idle) stores strobes without presetting the buffer. A gap of BUF_GAP ticks ends the mode (`load_active_o` falls) without a program start.
- R9: `clear_i` while idle sets every buffer byte to FFh.
- R10: A program window that times out with no byte stored returns to idle without a program start.
- R11: The offset comes from the falling-edge pulse and the data from the rising-edge pulse. A change on `addr_i` between the two does not move the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle microsecond tick |
| arm_prog_i | input | 1 | Program command accepted |
| arm_bufwr_i | input | 1 | Buffer-write command accepted |
| clear_i | input | 1 | Fill buffer with FFh |
| wr_fall_i | input | 1 | Strobe falling-edge pulse, captures address |
| wr_rise_i | input | 1 | Strobe rising-edge pulse, captures data |
| addr_i | input | 20 | Byte address: [19:7] page, [6:0] offset |
| data_i | input | 8 | Write data |
| rd_off_i | input | 7 | Buffer read offset |
| rd_data_o | output | 8 | Buffer byte at rd_off_i |
| prog_ack_i | input | 1 | Program engine took the page |
| prog_start_o | output | 1 | One-cycle program start |
| prog_page_o | output | 13 | Captured page number |
| prog_busy_o | output | 1 | Waiting for acknowledge |
| load_active_o | output | 1 | A load window is open |
| page_err_o | output | 1 | Strobe outside the captured page |

## Verification
The bench measures the program timeout to the exact cycle. A timer that is off by one, or that restarts on the wrong edge, would close the window one cycle early or late. It loads a repeated offset and checks that the first byte survives and that programming starts at once; a design that stored the terminator would show 00h. It moves the address between the two strobe pulses, which would expose a design that latched the offset on the rising edge. It also covers an empty timed-out window, a buffer-write mode that must neither preset nor program, and strobes and clears sent while busy, which must not corrupt the held page or its data.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLOAD = 2'd1,
    ST_BLOAD = 2'd2,
    ST_WAIT  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem[i] <= '1;
      else if (fill_i)                          mem[i] <= '1;
      else if (we_i && waddr_i == AW'(i))       mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  // R9 / R2: a fill leaves every location erased
  p_fill_erased_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (rdata_o == '1));
endmodule

// File: rtl/pgbuf_gap_timer.sv
module pgbuf_gap_timer #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && !clr_i && ((cnt_q + CW'(1)) == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || expire_o)  cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= cnt_q + CW'(1);
  end

  // R4: the count restarts after every expiry
  p_expire_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int OFF_W    = 7,
  parameter int DATA_W   = 8,
  parameter int PROG_GAP = 100,
  parameter int BUF_GAP  = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    arm_prog_i,
  input  logic                    arm_bufwr_i,
  input  logic                    clear_i,
  input  logic                    wr_fall_i,
  input  logic                    wr_rise_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [OFF_W-1:0]        rd_off_i,
  output logic [DATA_W-1:0]       rd_data_o,
  input  logic                    prog_ack_i,
  output logic                    prog_start_o,
  output logic [ADDR_W-OFF_W-1:0] prog_page_o,
  output logic                    prog_busy_o,
  output logic                    load_active_o,
  output logic                    page_err_o
);
  localparam int DEPTH  = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int MAXGAP = (PROG_GAP > BUF_GAP) ? PROG_GAP : BUF_GAP;
  localparam int CNT_W  = $clog2(MAXGAP + 1);

  ld_state_e         st_q;
  logic              low_q, have_q, term_q, err_q, start_q;
  logic [OFF_W-1:0]  off_q, prev_q;
  logic [PAGE_W-1:0] page_q;

  logic in_load, fall_ok, rise_ok, acc_prog, acc_buf, do_clear;
  logic expire, run, tmr_clr, buf_we, buf_fill, to_wait, to_idle;
  logic [CNT_W-1:0] limit;

  assign in_load  = (st_q == ST_PLOAD) || (st_q == ST_BLOAD);
  assign fall_ok  = in_load && wr_fall_i && !low_q;
  assign rise_ok  = in_load && wr_rise_i && low_q;
  assign acc_prog = (st_q == ST_IDLE) && arm_prog_i;
  assign acc_buf  = (st_q == ST_IDLE) && arm_bufwr_i && !arm_prog_i;
  assign do_clear = (st_q == ST_IDLE) && clear_i;
  assign buf_fill = acc_prog || do_clear;
  assign buf_we   = rise_ok && !term_q;

  assign run     = in_load && !low_q && !wr_fall_i;
  assign tmr_clr = acc_prog || acc_buf || fall_ok || rise_ok;
  assign limit   = (st_q == ST_BLOAD) ? CNT_W'(BUF_GAP) : CNT_W'(PROG_GAP);

  assign to_wait = (st_q == ST_PLOAD) && ((expire && have_q) || (rise_ok && term_q));
  assign to_idle = in_load && expire && !((st_q == ST_PLOAD) && have_q);

  pgbuf_gap_timer #(.CW(CNT_W)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .run_i    (run),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .expire_o (expire)
  );

  pgbuf_store #(.DEPTH(DEPTH), .AW(OFF_W), .DW(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fill_i  (buf_fill),
    .we_i    (buf_we),
    .waddr_i (off_q),
    .wdata_i (data_i),
    .raddr_i (rd_off_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      low_q   <= 1'b0;
      have_q  <= 1'b0;
      term_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      off_q   <= '0;
      prev_q  <= '0;
      page_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (acc_prog || acc_buf) begin
        st_q   <= acc_prog ? ST_PLOAD : ST_BLOAD;
        low_q  <= 1'b0;
        have_q <= 1'b0;
        term_q <= 1'b0;
        if (acc_prog) err_q <= 1'b0;
      end
      if (fall_ok) begin
        low_q <= 1'b1;
        off_q <= addr_i[OFF_W-1:0];
        if (st_q == ST_PLOAD) begin
          if (!have_q) page_q <= addr_i[ADDR_W-1:OFF_W];
          else if (addr_i[ADDR_W-1:OFF_W] != page_q) err_q <= 1'b1;
          // repeated offset marks the end of the load
          term_q <= have_q && (addr_i[OFF_W-1:0] == prev_q);
        end
      end
      if (rise_ok) begin
        low_q <= 1'b0;
        if (!term_q) begin
          have_q <= 1'b1;
          prev_q <= off_q;
        end
      end
      if (to_wait) begin
        st_q    <= ST_WAIT;
        start_q <= 1'b1;
      end else if (to_idle) begin
        st_q <= ST_IDLE;
      end
      if (st_q == ST_WAIT && prog_ack_i) st_q <= ST_IDLE;
    end
  end

  assign prog_start_o  = start_q;
  assign prog_page_o   = page_q;
  assign prog_busy_o   = (st_q == ST_WAIT);
  assign load_active_o = in_load;
  assign page_err_o    = err_q;

  // R4: single-cycle start, only when waiting on the engine
  p_start_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);
  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> prog_busy_o);
  // R7: page held and buffer untouched while busy
  p_page_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_o |=> $stable(prog_page_o));
  p_no_write_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_o |-> !(buf_we || buf_fill));
endmodule

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;
  localparam int PG = 100;
  localparam int BG = 30;

  logic clk = 0, rst_ni = 0;
  logic tick = 1, arm_prog = 0, arm_buf = 0, clr = 0, fall = 0, rise = 0, ack = 0;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0, rd_data;
  logic [6:0]  rd_off = '0;
  logic        start, busy, load, err;
  logic [12:0] page;

  int n_chk = 0, n_err = 0, n_start = 0;

  always #10 clk = ~clk;

  page_load_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .arm_prog_i(arm_prog),
    .arm_bufwr_i(arm_buf), .clear_i(clr), .wr_fall_i(fall), .wr_rise_i(rise),
    .addr_i(addr), .data_i(data), .rd_off_i(rd_off), .rd_data_o(rd_data),
    .prog_ack_i(ack), .prog_start_o(start), .prog_page_o(page),
    .prog_busy_o(busy), .load_active_o(load), .page_err_o(err)
  );

  always @(negedge clk) if (start) n_start++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] off, output logic [7:0] v);
    rd_off = off;
    #1 v = rd_data;
  endtask

  task automatic pulse_arm(input bit prog);
    @(negedge clk);
    if (prog) arm_prog = 1; else arm_buf = 1;
    @(negedge clk);
    arm_prog = 0; arm_buf = 0;
  endtask

  task automatic strobe(input logic [12:0] pg, input logic [6:0] off,
                        input logic [7:0] d, input bit move);
    @(negedge clk);
    addr = {pg, off}; fall = 1;
    @(negedge clk);
    fall = 0; rise = 1; data = d;
    if (move) addr = {pg, off ^ 7'h40};
    @(negedge clk);
    rise = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 load", load, 0);
    check("R1 busy", busy, 0);
    check("R1 start", start, 0);
    check("R1 err", err, 0);
    rd(7'd0, v);   check("R1 byte0", v, 8'hFF);
    rd(7'd127, v); check("R1 byte127", v, 8'hFF);
  endtask

  task automatic t_bufwr_clear();
    logic [7:0] v;
    int s0 = n_start;
    pulse_arm(0);
    check("R8 active", load, 1);
    strobe(13'd0, 7'd5, 8'h11, 0);
    repeat (BG + 2) @(negedge clk);
    check("R8 ended", load, 0);
    pulse_arm(0);
    strobe(13'd0, 7'd6, 8'h22, 0);
    repeat (BG + 2) @(negedge clk);
    rd(7'd5, v); check("R8 no preset", v, 8'h11);
    rd(7'd6, v); check("R8 stored", v, 8'h22);
    check("R8 no start", n_start, s0);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    rd(7'd5, v); check("R9 cleared5", v, 8'hFF);
    rd(7'd6, v); check("R9 cleared6", v, 8'hFF);
  endtask

  task automatic t_prog_timeout();
    logic [7:0] v;
    int s0;
    pulse_arm(0);
    strobe(13'd0, 7'd40, 8'h55, 0);
    repeat (BG + 2) @(negedge clk);
    s0 = n_start;
    pulse_arm(1);
    strobe(13'h1ABC, 7'd9, 8'hA5, 0);
    strobe(13'h1ABC, 7'd2, 8'h3C, 1);
    strobe(13'h1ABC, 7'd127, 8'h01, 0);
    repeat (PG - 1) @(negedge clk);
    check("R4 still loading", load, 1);
    check("R4 no early start", n_start, s0);
    @(negedge clk);
    check("R4 start", start, 1);
    check("R4 busy", busy, 1);
    check("R4 page", page, 13'h1ABC);
    @(negedge clk);
    check("R4 one pulse", start, 0);
    rd(7'd9, v);   check("R3 off9", v, 8'hA5);
    rd(7'd127, v); check("R3 off127", v, 8'h01);
    rd(7'd2, v);   check("R11 off2", v, 8'h3C);
    rd(7'd66, v);  check("R11 moved off", v, 8'hFF);
    rd(7'd40, v);  check("R2 preset", v, 8'hFF);
    strobe(13'h0001, 7'd9, 8'h00, 0);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    rd(7'd9, v); check("R7 byte kept", v, 8'hA5);
    check("R7 page held", page, 13'h1ABC);
    check("R7 still busy", busy, 1);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    check("R7 ack idle", busy, 0);
  endtask

  task automatic t_terminator();
    logic [7:0] v;
    pulse_arm(1);
    strobe(13'h0042, 7'd3, 8'h77, 0);
    strobe(13'h0042, 7'd3, 8'h00, 0);
    check("R5 start", start, 1);
    check("R5 busy", busy, 1);
    rd(7'd3, v); check("R5 first kept", v, 8'h77);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic t_page_err();
    logic [7:0] v;
    pulse_arm(1);
    strobe(13'd5, 7'd1, 8'h10, 0);
    check("R6 no err yet", err, 0);
    strobe(13'd6, 7'd2, 8'h20, 0);
    check("R6 err", err, 1);
    rd(7'd2, v); check("R6 stored", v, 8'h20);
    repeat (PG + 1) @(negedge clk);
    check("R6 page first", page, 13'd5);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    pulse_arm(1);
    check("R6 err cleared", err, 0);
    repeat (PG + 2) @(negedge clk);
  endtask

  task automatic t_empty();
    int s0 = n_start;
    pulse_arm(1);
    check("R10 loading", load, 1);
    repeat (PG + 2) @(negedge clk);
    check("R10 idle", load, 0);
    check("R10 not busy", busy, 0);
    check("R10 no start", n_start, s0);
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_bufwr_clear();
    t_prog_timeout();
    t_terminator();
    t_page_err();
    t_empty();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule